// File: doc/BRIEF.md
# Flash Program/Erase Status Engine

This block is the storage and timing core of a byte-wide flash memory model. A command decoder upstream issues three kinds of request: program one byte, erase the whole chip, and set the boot protection lock. A program can only clear bits, so the stored byte becomes the old byte ANDed with the new one. Erase returns every byte to 0xFF. The first `BOOT_LAST+1` bytes form the boot region. After the lock is set, no program and no erase can change them, and only a reset clears the lock.

Program and erase run on an internal countdown measured in clock cycles (`PROG_CYCLES`, `ERASE_CYCLES`). While the countdown runs, the block will not accept another request. Reads during that time return a status byte in place of array data. Software can watch bit 7 for data polling and bit 6 for toggling.

The request interface is valid/ready. `req_ready` is low for as long as an operation is timing. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the upstream decoder must keep its request pending. The read port has no back-pressure: every `rd_en` cycle produces exactly one `rd_valid` beat on the next cycle.

Top module: `flash_op_engine`

## Requirements
- R1: After reset every byte reads 0xFF, and `busy`, `locked` and `rd_valid` are all low.
- R2: An accepted program request (`req_op`=0) raises `busy` on the next cycle. `busy` stays high for exactly `PROG_CYCLES` cycles. When `busy` falls, the addressed byte holds the old value AND `req_data`.
- R3: An accepted erase request (`req_op`=1) keeps `busy` high for exactly `ERASE_CYCLES` cycles. After that every byte reads 0xFF, except bytes at addresses 0..`BOOT_LAST` while `locked` is high, which keep their values.
- R4: A lock request (`req_op`=2) raises `locked` on the next cycle and does not raise `busy`. `locked` then stays high until reset. Repeating the lock request, or sending `req_op`=3, has no effect.
- R5: While `locked` is high, a program request to an address at or below `BOOT_LAST` is accepted. It leaves `busy` low and does not change the stored byte.
- R6: A read with `rd_en` gives `rd_valid` high on the next cycle. If `busy` was low at the read, `rd_data` is the stored byte at `rd_addr`.
- R7: A read while a program is timing returns the complement of bit 7 of the loaded data in bit 7, and zeros in bits 5..0.
- R8: A read while `busy` is high returns the toggle flag in bit 6. The flag starts at 0 after reset and inverts after each such read. During an erase, bit 7 reads 0.
- R9: `req_ready` equals the inverse of `busy`. A request presented while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 0 program, 1 erase, 2 lock, 3 no-op |
| req_addr | input | ADDR_W | Program target address |
| req_data | input | 8 | Program data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 8 | Array byte or status byte |
| busy | output | 1 | Program or erase timing |
| locked | output | 1 | Boot protection active |

## Verification
Each result has a fixed due time. `rd_valid` and `rd_data` appear one cycle after `rd_en`. `locked` and the rise of `busy` appear one cycle after acceptance. `busy` falls `PROG_CYCLES` or `ERASE_CYCLES` cycles after acceptance, and the array change is visible to reads issued from that cycle on. A behavioural model in the bench advances on every rising edge from the same inputs. The bench compares every output with this model at the falling edge, so each result is checked in exactly the cycle it is due. Directed checks cover the locked-boot program, which completes without going busy, and the addresses on either side of the boot boundary.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_LOCK  = 2'd2,
    OP_NONE  = 2'd3
  } flash_op_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/flash_op_timer.sv
// Shared countdown for program and erase; running is the busy state.
module flash_op_timer #(
  parameter int unsigned PROG_CYCLES  = 6,
  parameter int unsigned ERASE_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_erase,
  output logic running,
  output logic expire
);
  localparam int unsigned MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt   <= '0;
    end else if (start_prog) begin
      run_q <= 1'b1;
      cnt   <= CW'(PROG_CYCLES - 1);
    end else if (start_erase) begin
      run_q <= 1'b1;
      cnt   <= CW'(ERASE_CYCLES - 1);
    end else if (run_q) begin
      if (cnt == '0) run_q <= 1'b0;
      else           cnt   <= cnt - 1'b1;
    end
  end

  assign running = run_q;
  assign expire  = run_q && (cnt == '0);
endmodule

// File: rtl/flash_cell_array.sv
// Byte cells with AND-only programming, bulk erase and per-cell boot guard.
module flash_cell_array
  import flash_eng_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BOOT_LAST = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_prog,
  input  logic              commit_erase,
  input  logic              lock_on,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_word
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][7:0] cells;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam bit IN_BOOT = (i <= BOOT_LAST);
    logic [7:0] q;
    logic       guard;

    if (IN_BOOT) begin : g_boot
      assign guard = lock_on;
    end else begin : g_main
      assign guard = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= ERASED_BYTE;
      end else if (!guard) begin
        if (commit_erase)
          q <= ERASED_BYTE;
        else if (commit_prog && (wr_addr == ADDR_W'(i)))
          q <= q & wr_data;
      end
    end

    assign cells[i] = q;
  end

  assign rd_word = cells[rd_addr];
endmodule

// File: rtl/flash_read_port.sv
// Registered read path; substitutes a polling/toggle status byte while busy.
module flash_read_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       busy,
  input  logic       erasing,
  input  logic       pend_msb,
  input  logic [7:0] arr_word,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  logic tog;
  logic poll_bit;

  assign poll_bit = erasing ? 1'b0 : ~pend_msb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      tog      <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (busy) begin
          rd_data <= {poll_bit, tog, 6'b0};
          tog     <= ~tog;
        end else begin
          rd_data <= arr_word;
        end
      end
    end
  end
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_eng_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned BOOT_LAST    = 31,
  parameter int unsigned PROG_CYCLES  = 6,
  parameter int unsigned ERASE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              locked
);
  localparam logic [ADDR_W-1:0] BOOT_TOP = ADDR_W'(BOOT_LAST);

  flash_op_e         op;
  logic              accept, boot_hit, start_prog, start_erase;
  logic              running, expire;
  logic              lock_q, op_is_erase;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;
  logic [7:0]        arr_word;

  assign op          = flash_op_e'(req_op);
  assign req_ready   = !running;
  assign accept      = req_valid && !running;
  assign boot_hit    = (req_addr <= BOOT_TOP);
  assign start_prog  = accept && (op == OP_PROG) && !(lock_q && boot_hit);
  assign start_erase = accept && (op == OP_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q      <= 1'b0;
      op_is_erase <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
    end else begin
      if (accept && (op == OP_LOCK)) lock_q <= 1'b1;
      if (start_prog) begin
        op_is_erase <= 1'b0;
        op_addr     <= req_addr;
        op_data     <= req_data;
      end else if (start_erase) begin
        op_is_erase <= 1'b1;
      end
    end
  end

  flash_op_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_prog (start_prog),
    .start_erase(start_erase),
    .running    (running),
    .expire     (expire)
  );

  flash_cell_array #(
    .ADDR_W   (ADDR_W),
    .BOOT_LAST(BOOT_LAST)
  ) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_prog (expire && !op_is_erase),
    .commit_erase(expire && op_is_erase),
    .lock_on     (lock_q),
    .wr_addr     (op_addr),
    .wr_data     (op_data),
    .rd_addr     (rd_addr),
    .rd_word     (arr_word)
  );

  flash_read_port u_rdport (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .busy    (running),
    .erasing (op_is_erase),
    .pend_msb(op_data[7]),
    .arr_word(arr_word),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  assign busy   = running;
  assign locked = lock_q;
endmodule

// File: rtl/flash_op_engine_chk.sv
module flash_op_engine_chk #(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned BOOT_LAST    = 31,
  parameter int unsigned PROG_CYCLES  = 6,
  parameter int unsigned ERASE_CYCLES = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic [7:0]        rd_data,
  input logic              busy,
  input logic              locked
);
  localparam int unsigned MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;

  logic        boot_req;
  logic [31:0] run_len;

  assign boot_req = (32'(req_addr) <= BOOT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= '0;
  end

  AST_PROG_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0 && !(locked && boot_req)) |=> busy); // R2
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < MAXC)); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R4
  AST_LOCK_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd2) |=> (locked && !busy)); // R4
  AST_BOOT_PROG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0 && locked && boot_req) |=> !busy); // R5
  AST_READ_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R6
  AST_NO_STRAY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R6
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rd_data[5:0] == 6'd0)); // R7
  AST_BUSY_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req_ready && req_valid && req_op == 2'd2 && !locked) |=> !locked); // R9
endmodule

bind flash_op_engine flash_op_engine_chk #(
  .ADDR_W      (ADDR_W),
  .BOOT_LAST   (BOOT_LAST),
  .PROG_CYCLES (PROG_CYCLES),
  .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (.*);

// File: tb/test_flash_op_engine.sv
module test_flash_op_engine;
  localparam int ADDR_W = 8;
  localparam int BOOT_LAST = 31;
  localparam int PROG_CYCLES = 6;
  localparam int ERASE_CYCLES = 20;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd3;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic req_ready, rd_valid, busy, locked;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  flash_op_engine #(
    .ADDR_W(ADDR_W), .BOOT_LAST(BOOT_LAST),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) i_flash_op_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .locked(locked)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Behavioural reference model
  logic [7:0] m_mem [DEPTH];
  bit m_busy, m_erase, m_lock, m_tog, m_rdv, m_pb;
  int m_cnt;
  int m_pa;
  logic [7:0] m_pd, m_rdd;
  string m_rtag = "R6";

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) m_mem[a] = 8'hFF;
      m_busy = 0; m_erase = 0; m_lock = 0; m_tog = 0; m_rdv = 0; m_cnt = 0;
      m_rdd = 8'h00; m_pd = 8'h00; m_pa = 0;
    end else begin
      if (rd_en) begin
        m_rdv = 1;
        if (m_busy) begin
          m_rdd = {(m_erase ? 1'b0 : ~m_pd[7]), m_tog, 6'b0};
          m_rtag = m_erase ? "R8 erase status" : "R7 program status";
          m_tog = !m_tog;
        end else begin
          m_rdd = m_mem[rd_addr];
          m_rtag = "R6 array read";
        end
      end else m_rdv = 0;
      m_pb = m_busy;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          if (!m_erase) begin
            if (!(m_lock && m_pa <= BOOT_LAST)) m_mem[m_pa] = m_mem[m_pa] & m_pd;
          end else begin
            for (int a = 0; a < DEPTH; a++)
              if (!(m_lock && a <= BOOT_LAST)) m_mem[a] = 8'hFF;
          end
        end
      end
      if (req_valid && !m_pb) begin
        case (req_op)
          2'd0: if (!(m_lock && req_addr <= BOOT_LAST)) begin
                  m_busy = 1; m_cnt = PROG_CYCLES; m_erase = 0;
                  m_pa = int'(req_addr); m_pd = req_data;
                end
          2'd1: begin m_busy = 1; m_cnt = ERASE_CYCLES; m_erase = 1; end
          2'd2: m_lock = 1;
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R9 req_ready", req_ready, !m_busy);
      check(m_erase ? "R3 busy" : "R2 busy", busy, m_busy);
      check("R4 locked", locked, m_lock);
      check("R6 rd_valid", rd_valid, m_rdv);
      if (m_rdv) check(m_rtag, rd_data, m_rdd);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog R2: actual busy %0d expected 0", busy);
      wrap_up();
    end
  end

  task automatic req(logic [1:0] op, logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0; req_op = 2'd3;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 busy after reset", busy, 0);
    check("R1 locked after reset", locked, 0);
    check("R1 rd_valid after reset", rd_valid, 0);
    rd(8'h00); check("R1 erased byte 0x00", rd_data, 8'hFF);
    rd(8'hFF); check("R1 erased byte 0xFF", rd_data, 8'hFF);

    // R2 / R7 / R8: program with polling reads
    req(2'd0, 8'h40, 8'hA5);
    rd(8'h40); rd(8'h40); rd(8'h13);
    wait_idle();
    rd(8'h40); check("R2 program result", rd_data, 8'hA5);
    req(2'd0, 8'h40, 8'h3C);          // R2 AND semantics -> 0x24
    // R9: request while busy is dropped
    @(negedge clk); req_valid = 1; req_op = 2'd2;
    @(negedge clk); req_valid = 0; req_op = 2'd3;
    check("R9 lock ignored while busy", locked, 0);
    wait_idle();
    rd(8'h40); check("R2 AND result", rd_data, 8'h24);
    req(2'd0, 8'h05, 8'h0F); wait_idle(); // unlocked boot program
    rd(8'h05); check("R2 boot unlocked", rd_data, 8'h0F);

    // R3 / R8: erase with status reads
    req(2'd1, 8'h00, 8'h00);
    rd(8'h40); rd(8'h40);
    wait_idle();
    rd(8'h40); check("R3 erased main", rd_data, 8'hFF);
    rd(8'h05); check("R3 erased boot unlocked", rd_data, 8'hFF);

    // R4 / R5: lock and protection boundaries
    req(2'd0, 8'h05, 8'h12); wait_idle();
    req(2'd0, BOOT_LAST[ADDR_W-1:0], 8'h77); wait_idle();
    req(2'd0, 8'h80, 8'h34); wait_idle();
    req(2'd2, 8'h00, 8'h00);
    check("R4 locked set", locked, 1);
    check("R4 lock no busy", busy, 0);
    req(2'd2, 8'h00, 8'h00);
    req(2'd3, 8'h00, 8'h00);           // R4 no-op code
    req(2'd0, 8'h05, 8'h00);
    check("R5 locked boot no busy", busy, 0);
    rd(8'h05); check("R5 boot byte kept", rd_data, 8'h12);
    req(2'd0, BOOT_LAST[ADDR_W-1:0], 8'h00);
    check("R5 boundary no busy", busy, 0);
    req(2'd0, 8'(BOOT_LAST + 1), 8'h5A);
    check("R2 above boundary busy", busy, 1);
    wait_idle();
    rd(8'(BOOT_LAST + 1)); check("R2 above boundary data", rd_data, 8'h5A);
    req(2'd1, 8'h00, 8'h00); wait_idle();
    rd(8'h05); check("R3 locked boot kept", rd_data, 8'h12);
    rd(BOOT_LAST[ADDR_W-1:0]); check("R3 boundary kept", rd_data, 8'h77);
    rd(8'h80); check("R3 main erased", rd_data, 8'hFF);
    check("R4 still locked", locked, 1);

    repeat (3) @(negedge clk);
    finished = 1;
    wrap_up();
  end
endmodule